// File: doc/BRIEF.md
# PLL Frequency Verify-and-Retry Controller

This block confirms that a phase-locked loop has settled on the intended output frequency. It runs on the counted clock, which an external glitch-free selector has already switched to the PLL output. One of two trigger sources is passed through a synchronizer: a slow reference clock or an external pin. The block then counts counted-clock cycles across a window of N+1 trigger periods. At the end of the window it compares the count against a ±5% band around a programmed expected value.

When a measurement fails, the block drops the PLL enable for one cycle, raises it again, and measures again. A rising enable makes the PLL re-run its lock search. This repeats up to a programmable number of retries. If the last attempt also fails, the block raises a lock-error flag and stops. A timeout guards against trigger edges that never arrive. A saturating counter guards against windows that are too long.

Software writes the configuration, pulses `start`, and waits for `done`. It then reads `pass`, `lock_err` and the captured count.

Top module: `pll_freq_verify`

## Requirements
- R1: After reset, `pll_en`, `done`, `pass` and `lock_err` are all 0.
- R2: The window opens on a synchronized rising edge of the selected trigger and closes on the (N+1)th rising edge after it, where N is the 4-bit `cfg_periods` value (0 gives one period, 15 gives sixteen). `meas_count` equals the number of counted-clock cycles between those two edges.
- R3: A `cfg_trig_sel` value of 1 selects `trig_ref` as the trigger. A value of 0 selects `trig_pin`.
- R4: A start with `cfg_clk_sel` equal to 4 runs a measurement. Any other value ends at once with `done`=1, `pass`=0 and `lock_err`=0, and `pll_en` does not change.
- R5: With expected value E, a measurement passes only if E − floor(E/20) ≤ count ≤ E + floor(E/20).
- R6: The count saturates at 2^CW−1 instead of wrapping. A saturated count always fails.
- R7: With timeout T, a measurement fails if the opening edge does not arrive within T+1 cycles of arming. It also fails if the closing edge comes more than T+1 cycles after the opening edge.
- R8: After a failed measurement with retries left, `pll_en` goes low for exactly one cycle, goes high again, and a new measurement follows. Timeouts are retried in the same way.
- R9: With retry limit M, after M+1 failed measurements `lock_err`=1, `done`=1 and `pass`=0, and `pll_en` stays high with no further toggling.
- R10: Each accepted run clears `done`, `pass` and `lock_err` and starts with a one-cycle low pulse on `pll_en`. `pass` is never 1 in the cycle where `pll_en` rises.
- R11: If the closing edge and the timeout limit fall in the same cycle, the closing edge wins and the measurement is judged on its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counted clock (PLL output after external selection) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a verify sequence when idle |
| trig_ref | input | 1 | Slow reference clock used as a trigger |
| trig_pin | input | 1 | External pin used as a trigger |
| cfg_clk_sel | input | 3 | Counted-clock select; 4 means PLL output |
| cfg_trig_sel | input | 1 | Trigger select: 1 reference, 0 pin |
| cfg_periods | input | PW | Window length minus one, in trigger periods |
| cfg_exp_val | input | CW | Expected count |
| cfg_timeout | input | TW | Timeout limit in counted-clock cycles |
| cfg_max_retry | input | RW | Maximum number of retries |
| pll_en | output | 1 | PLL enable |
| meas_count | output | CW | Captured window count |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Frequency accepted |
| lock_err | output | 1 | Sticky error after the final failed attempt |

## Verification
Two functions can fall in the same cycle: the window-closing trigger edge and the timeout limit. The bench first runs with a generous timeout and measures a known window length D, set by a deterministic trigger generator that restarts on every enable rise. It then sets the timeout to D−1, so the closing edge and the limit coincide, and expects a pass with a count of D. It then sets the timeout to D−2 and expects a timeout failure.

// File: rtl/pfv_pkg.sv
package pfv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFF,
    ST_ARM,
    ST_COUNT,
    ST_EVAL
  } pfv_state_e;

  localparam logic [2:0] CLK_SEL_PLL  = 3'd4;
endpackage

// File: rtl/pfv_trig_sync.sv
module pfv_trig_sync #(
  parameter int NUM  = 2,
  parameter int SYNC = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM-1:0]                        trig_i,
  input  logic [((NUM > 1) ? $clog2(NUM) : 1)-1:0] sel_i,
  output logic                                  rise_o
);
  logic [NUM-1:0] rise_v;

  for (genvar g = 0; g < NUM; g++) begin : g_ch
    logic [SYNC:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC-1:0], trig_i[g]};
    end
    assign rise_v[g] = sh_q[SYNC-1] & ~sh_q[SYNC];
  end

  assign rise_o = rise_v[sel_i];

  // A synchronized rising edge on one channel cannot repeat on the next cycle
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> (!rise_o || (sel_i != $past(sel_i))));
endmodule

// File: rtl/pfv_window_ctr.sv
module pfv_window_ctr #(
  parameter int CW = 12,
  parameter int TW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          cnt_en_i,
  input  logic          tmo_en_i,
  input  logic          rise_i,
  input  logic [PW-1:0] periods_i,
  input  logic [TW-1:0] limit_i,
  output logic [CW-1:0] count_o,
  output logic          win_last_o,
  output logic          tmo_hit_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] ecnt_q, ecnt_d;
  logic [TW-1:0] tmo_q, tmo_d;

  always_comb begin
    cnt_d  = cnt_q;
    ecnt_d = ecnt_q;
    tmo_d  = tmo_q;
    if (clr_i) begin
      cnt_d  = '0;
      ecnt_d = '0;
      tmo_d  = '0;
    end else begin
      if (cnt_en_i && (cnt_q != CNT_MAX)) cnt_d  = cnt_q + 1'b1;
      if (cnt_en_i && rise_i)             ecnt_d = ecnt_q + 1'b1;
      if (tmo_en_i)                       tmo_d  = tmo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ecnt_q <= '0;
      tmo_q  <= '0;
    end else begin
      if (clr_i || cnt_en_i) cnt_q  <= cnt_d;
      if (clr_i || cnt_en_i) ecnt_q <= ecnt_d;
      if (clr_i || tmo_en_i) tmo_q  <= tmo_d;
    end
  end

  assign count_o    = cnt_q;
  assign win_last_o = rise_i && (ecnt_q == periods_i);
  assign tmo_hit_o  = (tmo_q == limit_i);

  assert_count_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_i && !clr_i && (cnt_q == CNT_MAX)) |=> (cnt_q == CNT_MAX));
  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_i && !clr_i && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pfv_band_chk.sv
module pfv_band_chk #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] exp_i,
  input  logic [CW-1:0] count_i,
  output logic          in_band_o
);
  localparam logic [CW-1:0] DIV     = CW'(20);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] lo_q, lo_d, margin;
  logic [CW:0]   hi_q, hi_d;

  always_comb begin
    margin = exp_i / DIV;
    lo_d   = exp_i - margin;
    hi_d   = {1'b0, exp_i} + {1'b0, margin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load_i) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign in_band_o = (count_i >= lo_q) && ({1'b0, count_i} <= hi_q) &&
                     (count_i != CNT_MAX);
endmodule

// File: rtl/pll_freq_verify.sv
module pll_freq_verify
  import pfv_pkg::*;
#(
  parameter int CW = 12,
  parameter int TW = 16,
  parameter int PW = 4,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          trig_ref,
  input  logic          trig_pin,
  input  logic [2:0]    cfg_clk_sel,
  input  logic          cfg_trig_sel,
  input  logic [PW-1:0] cfg_periods,
  input  logic [CW-1:0] cfg_exp_val,
  input  logic [TW-1:0] cfg_timeout,
  input  logic [RW-1:0] cfg_max_retry,
  output logic          pll_en,
  output logic [CW-1:0] meas_count,
  output logic          done,
  output logic          pass,
  output logic          lock_err
);
  localparam int NUM_TRIG = 2;

  pfv_state_e    state_q, state_d;
  logic          pll_en_q, pll_en_d;
  logic          done_q, done_d, pass_q, pass_d, lerr_q, lerr_d;
  logic          tflag_q, tflag_d;
  logic [RW-1:0] retry_q, retry_d;
  logic          clr, cnt_en, tmo_en, load;
  logic          trig_rise, win_last, tmo_hit, in_band;

  pfv_trig_sync #(.NUM(NUM_TRIG), .SYNC(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i ({trig_ref, trig_pin}),
    .sel_i  (cfg_trig_sel),
    .rise_o (trig_rise)
  );

  pfv_window_ctr #(.CW(CW), .TW(TW), .PW(PW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .cnt_en_i   (cnt_en),
    .tmo_en_i   (tmo_en),
    .rise_i     (trig_rise),
    .periods_i  (cfg_periods),
    .limit_i    (cfg_timeout),
    .count_o    (meas_count),
    .win_last_o (win_last),
    .tmo_hit_o  (tmo_hit)
  );

  pfv_band_chk #(.CW(CW)) u_band (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .exp_i     (cfg_exp_val),
    .count_i   (meas_count),
    .in_band_o (in_band)
  );

  always_comb begin
    state_d  = state_q;
    pll_en_d = pll_en_q;
    done_d   = done_q;
    pass_d   = pass_q;
    lerr_d   = lerr_q;
    tflag_d  = tflag_q;
    retry_d  = retry_q;
    clr      = 1'b0;
    cnt_en   = 1'b0;
    tmo_en   = 1'b0;
    load     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          pass_d  = 1'b0;
          lerr_d  = 1'b0;
          retry_d = '0;
          if (cfg_clk_sel == CLK_SEL_PLL) begin
            done_d   = 1'b0;
            pll_en_d = 1'b0;
            state_d  = ST_OFF;
          end else begin
            done_d   = 1'b1;
          end
        end
      end
      ST_OFF: begin
        clr      = 1'b1;
        load     = 1'b1;
        tflag_d  = 1'b0;
        pll_en_d = 1'b1;
        state_d  = ST_ARM;
      end
      ST_ARM: begin
        tmo_en = 1'b1;
        if (trig_rise) begin
          clr     = 1'b1;
          state_d = ST_COUNT;
        end else if (tmo_hit) begin
          tflag_d = 1'b1;
          state_d = ST_EVAL;
        end
      end
      ST_COUNT: begin
        cnt_en = 1'b1;
        tmo_en = 1'b1;
        if (win_last) begin
          state_d = ST_EVAL;
        end else if (tmo_hit) begin
          tflag_d = 1'b1;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (in_band && !tflag_q) begin
          pass_d  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (retry_q < cfg_max_retry) begin
          retry_d  = retry_q + 1'b1;
          pll_en_d = 1'b0;
          state_d  = ST_OFF;
        end else begin
          lerr_d  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pll_en_q <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      lerr_q   <= 1'b0;
      tflag_q  <= 1'b0;
      retry_q  <= '0;
    end else begin
      state_q  <= state_d;
      pll_en_q <= pll_en_d;
      done_q   <= done_d;
      pass_q   <= pass_d;
      lerr_q   <= lerr_d;
      tflag_q  <= tflag_d;
      retry_q  <= retry_d;
    end
  end

  assign pll_en   = pll_en_q;
  assign done     = done_q;
  assign pass     = pass_q;
  assign lock_err = lerr_q;

  assert_no_pass_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en_q) |-> !pass_q);
  assert_lock_err_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lerr_q |-> (done_q && !pass_q));
  assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |-> !pll_en_q);
  assert_off_then_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |=> pll_en_q);
  assert_timeout_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_COUNT) && tmo_hit && !win_last) |=> ((state_q == ST_EVAL) && tflag_q));
  assert_edge_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_COUNT) && win_last) |=> ((state_q == ST_EVAL) && !tflag_q));
  assert_bad_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && start && (cfg_clk_sel != CLK_SEL_PLL)) |=>
      (done_q && !pass_q && $stable(pll_en_q)));
endmodule

// File: tb/pll_freq_verify_test.sv
module pll_freq_verify_test;
  localparam int CW = 10, TW = 12, PW = 4, RW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic trig_ref = 1'b0, trig_pin = 1'b0;
  logic [2:0] cfg_clk_sel = 3'd4;
  logic cfg_trig_sel = 1'b1;
  logic [PW-1:0] cfg_periods = '0;
  logic [CW-1:0] cfg_exp_val = '0;
  logic [TW-1:0] cfg_timeout = '1;
  logic [RW-1:0] cfg_max_retry = '0;
  logic pll_en, done, pass, lock_err;
  logic [CW-1:0] meas_count;

  pll_freq_verify #(.CW(CW), .TW(TW), .PW(PW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .trig_ref(trig_ref), .trig_pin(trig_pin),
    .cfg_clk_sel(cfg_clk_sel), .cfg_trig_sel(cfg_trig_sel), .cfg_periods(cfg_periods),
    .cfg_exp_val(cfg_exp_val), .cfg_timeout(cfg_timeout), .cfg_max_retry(cfg_max_retry),
    .pll_en(pll_en), .meas_count(meas_count), .done(done), .pass(pass), .lock_err(lock_err)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int h_ref = 20, h_pin = 31, h_bad = 27, bad_n = 0;
  int gen_rises = 0, base_rises = 0, ph_r = 0, ph_p = 0, hr = 0;
  logic gen_prev = 1'b0;
  int r_count, r_pass, r_lerr, r_rises, r_lows, r_pass0;

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_up();
    end
  end

  // Trigger generator: restarts from low on every enable rise
  always @(negedge clk) begin
    if (pll_en && !gen_prev) begin
      gen_rises++;
      trig_ref = 1'b0; trig_pin = 1'b0; ph_r = 0; ph_p = 0;
    end else begin
      hr = ((bad_n > 0) && ((gen_rises - base_rises) <= bad_n)) ? h_bad : h_ref;
      if (hr > 0) begin
        if (ph_r >= hr - 1) begin trig_ref = ~trig_ref; ph_r = 0; end else ph_r++;
      end
      if (h_pin > 0) begin
        if (ph_p >= h_pin - 1) begin trig_pin = ~trig_pin; ph_p = 0; end else ph_p++;
      end
    end
    gen_prev = pll_en;
  end

  task automatic run();
    logic prev;
    int w;
    @(posedge clk); base_rises = gen_rises;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    r_pass0 = pass;
    r_lows  = !pll_en;
    r_rises = 0;
    prev    = pll_en;
    w = 0;
    while (!done) begin
      @(negedge clk);
      if (!pll_en) r_lows++;
      if (pll_en && !prev) r_rises++;
      prev = pll_en;
      w++;
      if (w > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog run actual=%0d expected=done", w);
        finish_up();
      end
    end
    r_count = meas_count; r_pass = pass; r_lerr = lock_err;
  endtask

  initial begin
    int n, d, e, step, lo, hi, ecnt, epass, tsel, hsel, quiet;
    repeat (3) @(negedge clk);
    chk("R1 pll_en at reset", pll_en, 0);
    chk("R1 done at reset", done, 0);
    chk("R1 pass at reset", pass, 0);
    chk("R1 lock_err at reset", lock_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pll_en after release", pll_en, 0);

    // Sweep window length, trigger choice and expected value (R2 R3 R5)
    cfg_timeout = 12'd4000; cfg_max_retry = '0;
    for (int c = 0; c < 8; c++) begin
      case (c % 4) 0: n = 0; 1: n = 1; 2: n = 2; default: n = 15; endcase
      tsel = (c < 4) ? 1 : 0;
      hsel = tsel ? h_ref : h_pin;
      d = (n + 1) * 2 * hsel;
      step = d / 100 + 1;
      for (int i = -12; i <= 12; i++) begin
        e = d + i * step;
        if (e < 1 || e > CMAX) continue;
        cfg_periods = PW'(n); cfg_trig_sel = tsel[0]; cfg_exp_val = CW'(e);
        run();
        ecnt  = (d > CMAX) ? CMAX : d;
        lo = e - e / 20; hi = e + e / 20;
        epass = (ecnt != CMAX) && (d >= lo) && (d <= hi);
        chk(tsel ? "R2 R3 count via reference" : "R2 R3 count via pin", r_count, ecnt);
        chk("R5 band verdict", r_pass, epass);
        chk("R9 lock_err with no retries", r_lerr, !epass);
        chk("R10 one enable low cycle", r_lows, 1);
      end
    end

    // Saturation (R6)
    h_ref = 40; cfg_trig_sel = 1'b1; cfg_periods = 4'd15; cfg_exp_val = 10'd1000;
    run();
    chk("R6 count saturates", r_count, CMAX);
    chk("R6 saturated count fails", r_pass, 0);
    h_ref = 20;

    // Edge vs timeout in the same cycle (R11) and one cycle short (R7)
    cfg_periods = 4'd1; cfg_exp_val = 10'd80; cfg_timeout = 12'd79;
    run();
    chk("R11 edge wins pass", r_pass, 1);
    chk("R11 edge wins count", r_count, 80);
    cfg_timeout = 12'd78;
    run();
    chk("R7 window timeout fails", r_pass, 0);
    chk("R7 window timeout lock_err", r_lerr, 1);

    // Missing opening edge, retried once (R7 R8)
    cfg_timeout = 12'd50; cfg_trig_sel = 1'b0; h_pin = 0; cfg_max_retry = 3'd1;
    run();
    chk("R7 no opening edge fails", r_pass, 0);
    chk("R8 timeout retried", r_rises, 2);
    chk("R9 lock_err after timeouts", r_lerr, 1);
    h_pin = 31; cfg_trig_sel = 1'b1; cfg_timeout = 12'd4000;

    // Pass first, then a retry run that recovers (R8 R10)
    cfg_max_retry = '0; run();
    chk("R5 pass before retry test", r_pass, 1);
    bad_n = 2; cfg_max_retry = 3'd3;
    run();
    chk("R10 pass cleared on start", r_pass0, 0);
    chk("R8 recovers after retries", r_pass, 1);
    chk("R8 enable rises per attempt", r_rises, 3);
    chk("R8 one low cycle per attempt", r_lows, 3);
    chk("R8 final count", r_count, 80);

    // Retries exhausted (R9)
    bad_n = 5;
    run();
    chk("R9 lock_err set", r_lerr, 1);
    chk("R9 pass low", r_pass, 0);
    chk("R9 attempts equal limit plus one", r_rises, 4);
    quiet = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (!pll_en || !done || !lock_err) quiet++;
    end
    chk("R9 no toggling after error", quiet, 0);
    bad_n = 0;

    // Clock select other than PLL output (R4)
    cfg_max_retry = '0; run();
    chk("R4 setup pass", r_pass, 1);
    cfg_clk_sel = 3'd3;
    run();
    chk("R4 done set", done, 1);
    chk("R4 pass low", r_pass, 0);
    chk("R4 lock_err low", r_lerr, 0);
    chk("R4 enable unchanged", pll_en, 1);
    chk("R4 no enable low", r_lows, 0);
    cfg_clk_sel = 3'd4;

    finish_up();
  end
endmodule